// File: doc/BRIEF.md
# Multi-Address Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (SCL clock, open-drain SDA data) that answers ten 7-bit device addresses. Eight of them select 256-byte nonvolatile scratchpad banks. One selects a 256-byte nonvolatile configuration bank. One selects a 256-byte volatile configuration bank. A bus master stores bytes with page writes of up to 16 bytes. It fetches them with current-address reads, random reads and sequential reads. The nonvolatile banks are behavioural arrays. When a nonvolatile write completes, the block holds a busy period of `WRITE_CYCLES` system clocks. During that period the slave answers no device address. A write-protect input suppresses nonvolatile commits only.

SCL and SDA are synchronised with two flops and edge-detected on the system clock. The block never drives SDA high. It pulls the line low through `sda_low_o`, and the bench or pad logic forms the wired-AND. A controller state machine steps through these states:

- `ST_IDLE`: no transfer.
- `ST_DEV_ADDR`: device byte being shifted in.
- `ST_DEV_ACK`, `ST_MEM_ACK`, `ST_WR_ACK`: slave ACK bits.
- `ST_MEM_ADDR`: memory address byte.
- `ST_WR_DATA`: data byte being written.
- `ST_RD_DATA`: slave transmitting a byte.
- `ST_RD_ACK`: master ACK or NACK bit.
- `ST_IGNORE`: frame not for this slave, or ended by a NACK.

A start moves every state to `ST_DEV_ADDR`, and a stop moves every state to `ST_IDLE`. Other transitions happen on the SCL falling edge that ends the ninth bit (or the eighth, before an ACK bit):

- `ST_DEV_ADDR` goes to `ST_DEV_ACK` on a match while not busy, and to `ST_IGNORE` otherwise.
- `ST_DEV_ACK` goes to `ST_RD_DATA` for a read, or to `ST_MEM_ADDR` for a write.
- `ST_MEM_ADDR` goes to `ST_MEM_ACK`, which goes to `ST_WR_DATA`.
- `ST_WR_DATA` and `ST_WR_ACK` alternate.
- `ST_RD_DATA` goes to `ST_RD_ACK`. `ST_RD_ACK` goes back to `ST_RD_DATA` on a master ACK, or to `ST_IGNORE` on a NACK.

Top module: `twi_multibank_slave`

## Requirements
- R1: A device byte whose upper 7 bits are 1000bbb selects scratchpad bank bbb. 1101000 selects the nonvolatile configuration bank, and 1101001 selects the volatile one. Any other address gets no ACK (SDA left high on the ninth clock), and the rest of that frame has no effect.
- R2: In a write frame (device byte with bit 0 = 0), the slave pulls SDA low on the ninth clock after the device byte, after the memory address byte and after every data byte. Data is committed at the stop, and each bank keeps its own contents.
- R3: During a write, only the low 4 bits of the memory address advance and the upper 4 bits stay fixed. A 17th byte therefore overwrites the first byte of the frame.
- R4: A stop after at least one data byte to a nonvolatile bank, with wp_i low, raises busy_o for exactly WRITE_CYCLES clocks. While busy_o is high, no device address is acknowledged. Writes to the volatile bank never raise busy_o.
- R5: If wp_i is high at the stop, nonvolatile banks keep their old contents and busy_o stays low, while every ACK of the frame is still given. A write to the volatile bank still takes effect.
- R6: The address pointer holds one more than the last byte written or read. A read frame sent without a memory address returns the byte at that pointer.
- R7: A write frame followed by a repeated start instead of a stop still sets the pointer, but stores none of its data bytes.
- R8: While reading, a master ACK (SDA low on the ninth clock) makes the slave send the next byte. A NACK makes it release SDA and send nothing more until the next start.
- R9: When a scratchpad read passes address FFh, it continues at 00h of the next bank, and bank 7 is followed by bank 0.
- R10: When a configuration-bank read passes address FFh, it continues at 00h of the same bank.
- R11: While reset is active and right after it, SDA is released and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wp_i | input | 1 | Write protect for nonvolatile banks, active high |
| busy_o | output | 1 | High during an internal nonvolatile write cycle |

## Verification
A corrupted pointer or bank register shows up in the next byte returned by a current-address or sequential read. For a rollover fault, that byte is the first one sent after address FFh. A state register that has slipped by one bit puts the ACK pulse on the wrong ninth clock, so the master sees a missing ACK within one byte time. A busy counter that is loaded or cleared wrongly shows up at the port at once: busy_o has the wrong length, a device address is answered during a write cycle, or an address is refused after the cycle has ended.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_MEM_ADDR,
        ST_MEM_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    // Extra top stage keeps the previous synchronised value for edge detection.
    logic [SYNC_STAGES:0] scl_p;
    logic [SYNC_STAGES:0] sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
            sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_d;
    logic sda_d;

    assign scl_s    = scl_p[SYNC_STAGES-1];
    assign sda_s    = sda_p[SYNC_STAGES-1];
    assign scl_d    = scl_p[SYNC_STAGES];
    assign sda_d    = sda_p[SYNC_STAGES];
    assign ev_rise  = scl_s & ~scl_d;
    assign ev_fall  = ~scl_s & scl_d;
    assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
    assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_bank_store.sv
module twi_bank_store #(
    parameter int TARGETS      = 10,
    parameter int TGT_W        = 4,
    parameter int ADDR_W       = 8,
    parameter int PAGE_BITS    = 4,
    parameter int VOL_TGT      = 9,
    parameter int WRITE_CYCLES = 200
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TGT_W-1:0]            rd_tgt,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [7:0]                  rd_data,
    input  logic                        pg_wr,
    input  logic [PAGE_BITS-1:0]        pg_idx,
    input  logic [7:0]                  pg_data,
    input  logic                        pg_clr,
    input  logic                        commit,
    input  logic [TGT_W-1:0]            cm_tgt,
    input  logic [ADDR_W-PAGE_BITS-1:0] cm_page,
    input  logic                        wp_i,
    output logic                        busy_o
);
    localparam int DEPTH     = TARGETS << ADDR_W;
    localparam int IDX_W     = TGT_W + ADDR_W;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;
    localparam int CNT_W     = $clog2(WRITE_CYCLES + 1);

    logic [7:0]           mem    [DEPTH];
    logic [7:0]           pg_buf [PAGE_SIZE];
    logic [PAGE_SIZE-1:0] pg_vld;
    logic [CNT_W-1:0]     busy_cnt;

    logic nv_target;
    logic allow;

    assign nv_target = (cm_tgt != TGT_W'(VOL_TGT));
    assign allow     = !nv_target || !wp_i;
    assign rd_data   = mem[IDX_W'({rd_tgt, rd_addr})];
    assign busy_o    = (busy_cnt != '0);

    for (genvar g = 0; g < PAGE_SIZE; g++) begin : g_page
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pg_vld[g] <= 1'b0;
            end else if (pg_clr || commit) begin
                pg_vld[g] <= 1'b0;
            end else if (pg_wr && pg_idx == PAGE_BITS'(g)) begin
                pg_vld[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (pg_wr && pg_idx == PAGE_BITS'(g)) begin
                pg_buf[g] <= pg_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (commit && allow) begin
            for (int i = 0; i < PAGE_SIZE; i++) begin
                if (pg_vld[i]) begin
                    mem[IDX_W'({cm_tgt, cm_page, PAGE_BITS'(i)})] <= pg_buf[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (commit && nv_target && !wp_i && (pg_vld != '0)) begin
            busy_cnt <= CNT_W'(WRITE_CYCLES);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/twi_multibank_slave.sv
module twi_multibank_slave
    import twi_pkg::*;
#(
    parameter int         DEV_W        = 7,
    parameter int         PREFIX_W     = 4,
    parameter logic [3:0] SCRATCH_PRE  = 4'b1000,
    parameter logic [6:0] CFG_NV_DEV   = 7'h68,
    parameter logic [6:0] CFG_VOL_DEV  = 7'h69,
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_BITS    = 4,
    parameter int         WRITE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_low_o,
    input  logic wp_i,
    output logic busy_o
);
    localparam int SEL_W          = DEV_W - PREFIX_W;
    localparam int SCRATCH_BLOCKS = 1 << SEL_W;
    localparam int TARGETS        = SCRATCH_BLOCKS + 2;
    localparam int TGT_W          = $clog2(TARGETS);
    localparam int NV_CFG_TGT     = SCRATCH_BLOCKS;
    localparam int VOL_TGT        = SCRATCH_BLOCKS + 1;
    localparam int CNT_W          = $clog2(BYTE_W + 1);

    logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop;

    twi_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    twi_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [7:0]        shreg, shreg_n;
    logic [7:0]        tx, tx_n;
    logic [ADDR_W-1:0] ptr, ptr_n;
    logic [TGT_W-1:0]  cur_tgt, cur_tgt_n;
    logic              rw, rw_n;
    logic              mack, mack_n;
    logic              drv, drv_n;

    logic              pg_wr, pg_clr, commit, load;
    logic [7:0]        rd_data;
    logic [SEL_W-1:0]  nxt_sel;
    logic              hit;
    logic [TGT_W-1:0]  hit_tgt;

    twi_bank_store #(
        .TARGETS      (TARGETS),
        .TGT_W        (TGT_W),
        .ADDR_W       (ADDR_W),
        .PAGE_BITS    (PAGE_BITS),
        .VOL_TGT      (VOL_TGT),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_tgt  (cur_tgt),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .pg_wr   (pg_wr),
        .pg_idx  (ptr[PAGE_BITS-1:0]),
        .pg_data (shreg),
        .pg_clr  (pg_clr),
        .commit  (commit),
        .cm_tgt  (cur_tgt),
        .cm_page (ptr[ADDR_W-1:PAGE_BITS]),
        .wp_i    (wp_i),
        .busy_o  (busy_o)
    );

    // Device address decode: scratchpad prefix plus bank select, or one of two config addresses.
    always_comb begin
        hit     = 1'b0;
        hit_tgt = '0;
        if (shreg[7:8-PREFIX_W] == SCRATCH_PRE) begin
            hit     = 1'b1;
            hit_tgt = TGT_W'(shreg[SEL_W:1]);
        end else if (shreg[7:1] == CFG_NV_DEV) begin
            hit     = 1'b1;
            hit_tgt = TGT_W'(NV_CFG_TGT);
        end else if (shreg[7:1] == CFG_VOL_DEV) begin
            hit     = 1'b1;
            hit_tgt = TGT_W'(VOL_TGT);
        end
    end

    assign nxt_sel = cur_tgt[SEL_W-1:0] + 1'b1;

    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        shreg_n   = shreg;
        tx_n      = tx;
        ptr_n     = ptr;
        cur_tgt_n = cur_tgt;
        rw_n      = rw;
        mack_n    = mack;
        drv_n     = drv;
        pg_wr     = 1'b0;
        pg_clr    = 1'b0;
        commit    = 1'b0;
        load      = 1'b0;

        if (ev_stop) begin
            state_n = ST_IDLE;
            drv_n   = 1'b0;
            commit  = (state == ST_WR_DATA) || (state == ST_WR_ACK);
        end else if (ev_start) begin
            state_n = ST_DEV_ADDR;
            cnt_n   = '0;
            drv_n   = 1'b0;
            pg_clr  = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_DEV_ADDR, ST_MEM_ADDR, ST_WR_DATA: begin
                    if (ev_rise) begin
                        shreg_n = {shreg[6:0], sda_s};
                        cnt_n   = cnt + 1'b1;
                    end else if (ev_fall && cnt == CNT_W'(BYTE_W)) begin
                        drv_n = 1'b1;
                        if (state == ST_DEV_ADDR) begin
                            if (hit && !busy_o) begin
                                cur_tgt_n = hit_tgt;
                                rw_n      = shreg[0];
                                state_n   = ST_DEV_ACK;
                            end else begin
                                drv_n   = 1'b0;
                                state_n = ST_IGNORE;
                            end
                        end else if (state == ST_MEM_ADDR) begin
                            ptr_n   = shreg;
                            state_n = ST_MEM_ACK;
                        end else begin
                            pg_wr   = 1'b1;
                            ptr_n   = {ptr[ADDR_W-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
                            state_n = ST_WR_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev_fall) begin
                        if (rw) begin
                            load = 1'b1;
                        end else begin
                            drv_n   = 1'b0;
                            cnt_n   = '0;
                            state_n = ST_MEM_ADDR;
                        end
                    end
                end
                ST_MEM_ACK, ST_WR_ACK: begin
                    if (ev_fall) begin
                        drv_n   = 1'b0;
                        cnt_n   = '0;
                        state_n = ST_WR_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (ev_fall) begin
                        if (cnt == CNT_W'(BYTE_W)) begin
                            drv_n   = 1'b0;
                            state_n = ST_RD_ACK;
                        end else begin
                            drv_n = ~tx[3'd7 - cnt[2:0]];
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise) begin
                        mack_n = ~sda_s;
                    end else if (ev_fall) begin
                        if (mack) begin
                            load = 1'b1;
                        end else begin
                            state_n = ST_IGNORE;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end

        // Fetch a byte for transmission, drive its MSB and advance the pointer.
        if (load) begin
            tx_n    = rd_data;
            drv_n   = ~rd_data[7];
            cnt_n   = CNT_W'(1);
            ptr_n   = ptr + 1'b1;
            state_n = ST_RD_DATA;
            if (cur_tgt < TGT_W'(SCRATCH_BLOCKS) && ptr == '1) begin
                cur_tgt_n = TGT_W'(nxt_sel);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            cur_tgt <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            drv     <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            shreg   <= shreg_n;
            tx      <= tx_n;
            ptr     <= ptr_n;
            cur_tgt <= cur_tgt_n;
            rw      <= rw_n;
            mack    <= mack_n;
            drv     <= drv_n;
        end
    end

    assign sda_low_o = drv;

endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk
    import twi_pkg::*;
#(
    parameter int WRITE_CYCLES = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       drive_low,
    input logic       busy,
    input logic       wp,
    input twi_state_e state
);
    logic [31:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_len <= '0;
        else if (!busy) busy_len <= '0;
        else            busy_len <= busy_len + 1'b1;
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == 32'(WRITE_CYCLES));

    // R4
    quiet_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> state != ST_DEV_ACK);

    // R5
    wp_blocks_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp));

    // R2
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low != $past(drive_low)) |-> !scl_s);

    // R8
    drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> (state == ST_DEV_ACK || state == ST_MEM_ACK ||
                       state == ST_WR_ACK  || state == ST_RD_DATA));

endmodule

bind twi_multibank_slave twi_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .drive_low (sda_low_o),
    .busy      (busy_o),
    .wp        (wp_i),
    .state     (state)
);

// File: tb/twi_multibank_slave_tb.sv
module twi_multibank_slave_tb;

    localparam int WCYC = 800;
    localparam int T    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_low, busy;
    logic sda_line;

    assign sda_line = sda_m & ~sda_low;

    always #2 clk = ~clk;

    twi_multibank_slave #(.WRITE_CYCLES(WCYC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_low_o (sda_low),
        .wp_i      (wp),
        .busy_o    (busy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] wbuf [20];
    logic [7:0] rbuf [20];

    typedef struct packed {
        logic [6:0] dev;
        logic [7:0] addr;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{7'h41, 8'h00, 8'hC1},
        '{7'h43, 8'h00, 8'hC3},
        '{7'h45, 8'h80, 8'hC5},
        '{7'h47, 8'h3C, 8'hC7},
        '{7'h42, 8'hFE, 8'h42},
        '{7'h68, 8'h05, 8'h11},
        '{7'h69, 8'h05, 8'h77}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b0; tick(T); scl_m = 1'b0; tick(T);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T);
        sda_m = 1'b0; tick(T); scl_m = 1'b0; tick(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(T); scl_m = 1'b1; tick(T);
        sda_m = 1'b1; tick(3 * T);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(T); scl_m = 1'b1; tick(2 * T); scl_m = 1'b0; tick(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T);
        ack = !sda_line;
        tick(T); scl_m = 1'b0; tick(T);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T);
            b[i] = sda_line;
            tick(T); scl_m = 1'b0; tick(T);
        end
        bit_out(give_ack ? 1'b0 : 1'b1);
        sda_m = 1'b1;
    endtask

    task automatic wr_bytes(input logic [6:0] dev, input logic [7:0] addr,
                            input int n, output bit ok);
        bit a;
        bus_start();
        send_byte({dev, 1'b0}, a);
        ok = a;
        if (a) begin
            send_byte(addr, a); ok &= a;
            for (int k = 0; k < n; k++) begin
                send_byte(wbuf[k], a); ok &= a;
            end
        end
        bus_stop();
    endtask

    task automatic rd_rand(input logic [6:0] dev, input logic [7:0] addr,
                           input int n, output bit ok);
        bit a;
        bus_start();
        send_byte({dev, 1'b0}, a); ok = a;
        send_byte(addr, a); ok &= a;
        bus_rstart();
        send_byte({dev, 1'b1}, a); ok &= a;
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    task automatic rd_cur(input logic [6:0] dev, input int n, output bit ok);
        bit a;
        bus_start();
        send_byte({dev, 1'b1}, a); ok = a;
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && busy; k++) tick(1);
        tick(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all R) actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ok, a;
        tick(6);
        // R11: reset state
        chk("R11 busy in reset", busy, 0);
        chk("R11 sda in reset", sda_low, 0);
        rst_n = 1'b1;
        tick(6);
        chk("R11 busy after reset", busy, 0);
        chk("R11 sda after reset", sda_low, 0);

        // R1 R2: vector table, one write then a random read per entry
        for (int v = 0; v < 7; v++) begin
            wbuf[0] = VECS[v].data;
            wr_bytes(VECS[v].dev, VECS[v].addr, 1, ok);
            chk("R2 write acks", ok, 1);
            wait_idle();
            rd_rand(VECS[v].dev, VECS[v].addr, 1, ok);
            chk("R1 read acks", ok, 1);
            chk("R2 readback", rbuf[0], VECS[v].data);
        end
        rd_rand(7'h41, 8'h00, 1, ok);
        chk("R2 bank 1 kept apart from bank 3", rbuf[0], 8'hC1);
        rd_rand(7'h68, 8'h05, 1, ok);
        chk("R1 nv config kept apart from volatile", rbuf[0], 8'h11);

        // R1: unmatched address gets no ACK, frame ignored
        bus_start();
        send_byte({7'h50, 1'b0}, a);
        chk("R1 foreign address nack", a, 0);
        send_byte(8'h05, a);
        chk("R1 foreign frame ignored", a, 0);
        bus_stop();

        // R3 R4 R6: 17-byte page write to the volatile bank
        for (int k = 0; k < 17; k++) wbuf[k] = 8'(k + 1);
        wr_bytes(7'h69, 8'h20, 17, ok);
        chk("R3 page acks", ok, 1);
        chk("R4 volatile write no busy", busy, 0);
        rd_cur(7'h69, 1, ok);
        chk("R6 current read after write", rbuf[0], 2);
        rd_rand(7'h69, 8'h20, 3, ok);
        chk("R3 17th overwrote first", rbuf[0], 17);
        chk("R8 sequential byte 2", rbuf[1], 2);
        chk("R8 sequential byte 3", rbuf[2], 3);
        rd_cur(7'h69, 1, ok);
        chk("R8 nack ended, pointer after last", rbuf[0], 4);
        rd_rand(7'h69, 8'h2F, 1, ok);
        chk("R3 last page slot", rbuf[0], 16);

        // R7: data then repeated start stores nothing
        bus_start();
        send_byte({7'h69, 1'b0}, a);
        send_byte(8'h21, a);
        send_byte(8'hEE, a);
        bus_rstart();
        send_byte({7'h69, 1'b1}, a);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
        chk("R7 pointer moved past data byte", rbuf[0], 3);
        rd_rand(7'h69, 8'h21, 1, ok);
        chk("R7 aborted data not stored", rbuf[0], 2);

        // R4: busy after nonvolatile write
        wbuf[0] = 8'h5A;
        wr_bytes(7'h40, 8'h10, 1, ok);
        chk("R4 busy raised", busy, 1);
        bus_start();
        send_byte({7'h40, 1'b0}, a);
        chk("R4 nack while busy", a, 0);
        bus_stop();
        bus_start();
        send_byte({7'h69, 1'b1}, a);
        chk("R4 volatile nack while busy", a, 0);
        bus_stop();
        wait_idle();
        chk("R4 busy cleared", busy, 0);
        rd_rand(7'h40, 8'h10, 1, ok);
        chk("R4 ack after busy", ok, 1);
        chk("R4 data committed", rbuf[0], 8'h5A);

        // R5: write protect
        wp = 1'b1;
        wbuf[0] = 8'h33;
        wr_bytes(7'h40, 8'h10, 1, ok);
        chk("R5 acks under wp", ok, 1);
        chk("R5 no busy under wp", busy, 0);
        rd_rand(7'h40, 8'h10, 1, ok);
        chk("R5 nv unchanged", rbuf[0], 8'h5A);
        wbuf[0] = 8'h78;
        wr_bytes(7'h69, 8'h05, 1, ok);
        rd_rand(7'h69, 8'h05, 1, ok);
        chk("R5 volatile written under wp", rbuf[0], 8'h78);
        wp = 1'b0;

        // R9: scratchpad rollover
        wbuf[0] = 8'h9F;
        wr_bytes(7'h47, 8'hFF, 1, ok); wait_idle();
        wbuf[0] = 8'h0A;
        wr_bytes(7'h40, 8'h00, 1, ok); wait_idle();
        rd_rand(7'h47, 8'hFF, 2, ok);
        chk("R9 bank 7 FF", rbuf[0], 8'h9F);
        chk("R9 bank 7 wraps to bank 0", rbuf[1], 8'h0A);
        wbuf[0] = 8'h4F;
        wr_bytes(7'h42, 8'hFF, 1, ok); wait_idle();
        rd_rand(7'h42, 8'hFE, 3, ok);
        chk("R9 bank 2 FE", rbuf[0], 8'h42);
        chk("R9 bank 2 FF", rbuf[1], 8'h4F);
        chk("R9 bank 2 rolls to bank 3", rbuf[2], 8'hC3);

        // R10: configuration bank wraps on itself
        wbuf[0] = 8'hD1;
        wr_bytes(7'h68, 8'hFF, 1, ok); wait_idle();
        wbuf[0] = 8'hD0;
        wr_bytes(7'h68, 8'h00, 1, ok); wait_idle();
        rd_rand(7'h68, 8'hFF, 2, ok);
        chk("R10 config FF", rbuf[0], 8'hD1);
        chk("R10 config wraps to own 00", rbuf[1], 8'hD0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule